// File: doc/BRIEF.md
# Breakdown-Driven Drive Amplitude Controller

This block sets the drive amplitude word for the RF input of an accelerating structure while the structure is being conditioned. Time is divided into observation windows measured in RF trigger pulses. Within each window the block counts breakdown pulses. When the window closes it compares the count with a programmable threshold. A count under the threshold raises the amplitude by a programmable step. Any other count lowers it by the same step. The result is always held between an operator-loaded lower limit and upper limit.

The amplitude word goes to the DAC path. An enable input stops the loop. While enable is low the amplitude stays where it is, and the window and breakdown counters are held at zero, so a fresh window begins when enable returns high. All control words are sampled at the clock edge that closes a window. The limits are assumed to satisfy lower limit <= upper limit.

Top module: `cond_amp_ctrl`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, amp_o is 0 and both the trigger count and the breakdown count are cleared.
- R2: A window closes on the clock edge where trig is high and the number of trig pulses in the window reaches win_len. A win_len of 0 acts as 1. amp_o changes only on a closing edge.
- R3: On a closing edge, if the breakdown count of the window is strictly less than bd_thresh, amp_o becomes amp_o + step, subject to R5 and R10.
- R4: On a closing edge, if the breakdown count is equal to or greater than bd_thresh, amp_o becomes amp_o - step, subject to R6 and R10.
- R5: An increase that exceeds amp_max, including one that overflows the AMP_W-bit word, gives exactly amp_max.
- R6: A decrease that falls below amp_min, including one where step is larger than amp_o, gives exactly amp_min.
- R7: A breakdown pulse in the same cycle as the closing trigger counts toward the closing window. The breakdown count starts again at zero in the next window.
- R8: While enable is low, amp_o holds its value and trig and breakdown have no effect. After enable returns high, a full window of win_len triggers is needed before the next step.
- R9: The breakdown count saturates at 2^CNT_W-1 and does not wrap. With CNT_W = 8, a window with 300 breakdowns and bd_thresh = 255 gives a decrease.
- R10: After every closing edge, amp_o lies within [amp_min, amp_max]. This holds even when the previous amp_o was outside those limits, for example after reset or after the limits change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Loop enable; low freezes amp_o and clears the counters |
| trig | input | 1 | One pulse per RF trigger |
| breakdown | input | 1 | One pulse per detected breakdown |
| win_len | input | WIN_W | Window length in trigger pulses (0 acts as 1) |
| bd_thresh | input | CNT_W | Breakdown count at which the step turns downward |
| step | input | AMP_W | Amplitude change per window |
| amp_min | input | AMP_W | Lower amplitude limit |
| amp_max | input | AMP_W | Upper amplitude limit |
| amp_o | output | AMP_W | Drive amplitude word to the DAC path |

## Verification
The hardest cases to reach from the ports are a saturated breakdown count and an amplitude sum that overflows the word. Each one needs a whole window to be built up before the single edge where the result is visible. The bench fills one window with 300 breakdown cycles before the closing triggers. It also loads a step close to the full word width while amp_o sits at the upper limit. For the case where the closing trigger and a breakdown land on the same edge, the bench runs a following breakdown-free window, which shows that the counter was cleared.

// File: rtl/cond_amp_pkg.sv
package cond_amp_pkg;
    typedef enum logic {
        STEP_UP   = 1'b0,
        STEP_DOWN = 1'b1
    } step_dir_e;
endpackage

// File: rtl/cac_window.sv
module cac_window #(
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             trig,
    input  logic [WIN_W-1:0] win_len,
    output logic             win_close
);
    localparam int EW = WIN_W + 1;

    typedef struct packed {
        logic [WIN_W-1:0] tcnt;
    } win_st_t;

    win_st_t st_d, st_q;
    logic [EW-1:0] limit_d;
    logic          reached_d;

    always_comb begin
        st_d      = st_q;
        limit_d   = (win_len == '0) ? EW'(1) : {1'b0, win_len};
        reached_d = ({1'b0, st_q.tcnt} + EW'(1)) >= limit_d;
        win_close = enable && trig && reached_d;
        if (!enable || win_close) begin
            st_d.tcnt = '0;
        end else if (trig) begin
            st_d.tcnt = st_q.tcnt + WIN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/cac_bd_counter.sv
module cac_bd_counter #(
    parameter int CNT_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic           breakdown,
    input  logic           win_close,
    output logic [CNT_W:0] bd_total
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } bd_st_t;

    bd_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        bd_total = {1'b0, st_q.cnt} + (CNT_W+1)'(breakdown);
        if (!enable || win_close) begin
            st_d.cnt = '0;
        end else if (bd_total[CNT_W]) begin
            st_d.cnt = '1;
        end else begin
            st_d.cnt = bd_total[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/cac_stepper.sv
module cac_stepper
    import cond_amp_pkg::*;
#(
    parameter int AMP_W = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_close,
    input  logic [CNT_W:0]   bd_total,
    input  logic [CNT_W-1:0] bd_thresh,
    input  logic [AMP_W-1:0] step,
    input  logic [AMP_W-1:0] amp_min,
    input  logic [AMP_W-1:0] amp_max,
    output logic [AMP_W-1:0] amp_o
);
    localparam int SW = AMP_W + 1;

    typedef struct packed {
        logic [AMP_W-1:0] amp;
    } amp_st_t;

    amp_st_t   st_d, st_q;
    step_dir_e dir_d;
    logic [SW-1:0]    sum_d;
    logic [AMP_W-1:0] diff_d;
    logic             under_d;

    always_comb begin
        st_d    = st_q;
        dir_d   = (bd_total < {1'b0, bd_thresh}) ? STEP_UP : STEP_DOWN;
        sum_d   = {1'b0, st_q.amp} + {1'b0, step};
        under_d = st_q.amp < step;
        diff_d  = st_q.amp - step;
        if (win_close) begin
            case (dir_d)
                STEP_UP: begin
                    if (sum_d > {1'b0, amp_max}) begin
                        st_d.amp = amp_max;
                    end else if (sum_d[AMP_W-1:0] < amp_min) begin
                        st_d.amp = amp_min;
                    end else begin
                        st_d.amp = sum_d[AMP_W-1:0];
                    end
                end
                default: begin
                    if (under_d || diff_d < amp_min) begin
                        st_d.amp = amp_min;
                    end else if (diff_d > amp_max) begin
                        st_d.amp = amp_max;
                    end else begin
                        st_d.amp = diff_d;
                    end
                end
            endcase
        end
        amp_o = st_q.amp;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/cond_amp_ctrl.sv
module cond_amp_ctrl #(
    parameter int AMP_W = 16,
    parameter int WIN_W = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             trig,
    input  logic             breakdown,
    input  logic [WIN_W-1:0] win_len,
    input  logic [CNT_W-1:0] bd_thresh,
    input  logic [AMP_W-1:0] step,
    input  logic [AMP_W-1:0] amp_min,
    input  logic [AMP_W-1:0] amp_max,
    output logic [AMP_W-1:0] amp_o
);
    logic           win_close;
    logic [CNT_W:0] bd_total;

    cac_window #(.WIN_W(WIN_W)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .trig      (trig),
        .win_len   (win_len),
        .win_close (win_close)
    );

    cac_bd_counter #(.CNT_W(CNT_W)) u_bd (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .breakdown (breakdown),
        .win_close (win_close),
        .bd_total  (bd_total)
    );

    cac_stepper #(.AMP_W(AMP_W), .CNT_W(CNT_W)) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_close (win_close),
        .bd_total  (bd_total),
        .bd_thresh (bd_thresh),
        .step      (step),
        .amp_min   (amp_min),
        .amp_max   (amp_max),
        .amp_o     (amp_o)
    );
endmodule

// File: rtl/cac_checker.sv
module cac_checker #(
    parameter int AMP_W = 16,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             win_close,
    input logic [CNT_W:0]   bd_total,
    input logic [CNT_W-1:0] bd_thresh,
    input logic [AMP_W-1:0] step,
    input logic [AMP_W-1:0] amp_min,
    input logic [AMP_W-1:0] amp_max,
    input logic [AMP_W-1:0] amp_o
);
    logic [AMP_W:0] up_w, dn_w;
    logic           lim_ok;

    always_comb begin
        up_w   = {1'b0, amp_o} + {1'b0, step};
        dn_w   = {1'b0, amp_o} - {1'b0, step};
        lim_ok = amp_min <= amp_max;
    end

    // R2: no change without a window close
    a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !win_close |=> $stable(amp_o));

    // R8: disabled loop keeps amplitude
    a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(amp_o));

    // R5 / R10: upper bound after a close
    a_r5_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (win_close && lim_ok) |=> amp_o <= $past(amp_max));

    // R6 / R10: lower bound after a close
    a_r6_lower: assert property (@(posedge clk) disable iff (!rst_n)
        (win_close && lim_ok) |=> amp_o >= $past(amp_min));

    // R3: plain increase
    a_r3_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (win_close && bd_total < {1'b0, bd_thresh} &&
         up_w <= {1'b0, amp_max} && up_w >= {1'b0, amp_min})
        |=> amp_o == $past(up_w[AMP_W-1:0]));

    // R4: plain decrease, equality counts as reaching the threshold
    a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (win_close && bd_total >= {1'b0, bd_thresh} && amp_o >= step &&
         dn_w >= {1'b0, amp_min} && dn_w <= {1'b0, amp_max})
        |=> amp_o == $past(dn_w[AMP_W-1:0]));
endmodule

bind cond_amp_ctrl cac_checker #(.AMP_W(AMP_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .win_close (win_close),
    .bd_total  (bd_total),
    .bd_thresh (bd_thresh),
    .step      (step),
    .amp_min   (amp_min),
    .amp_max   (amp_max),
    .amp_o     (amp_o)
);

// File: tb/sim_cond_amp_ctrl.sv
`timescale 1ns/1ps
module sim_cond_amp_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b1;
    logic        trig = 1'b0;
    logic        breakdown = 1'b0;
    logic [15:0] win_len = 16'd4;
    logic [7:0]  bd_thresh = 8'd2;
    logic [15:0] step = 16'd100;
    logic [15:0] amp_min = 16'd200;
    logic [15:0] amp_max = 16'd1000;
    logic [15:0] amp_o;

    int    n_chk = 0;
    int    n_err = 0;
    string cur_req = "R1";
    bit    started = 1'b0;
    bit    done = 1'b0;

    int m_amp = 0, m_tc = 0, m_bd = 0, m_wl = 1, m_tot = 0, m_r = 0;

    always #4 clk = ~clk;

    cond_amp_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .trig(trig),
        .breakdown(breakdown), .win_len(win_len), .bd_thresh(bd_thresh),
        .step(step), .amp_min(amp_min), .amp_max(amp_max), .amp_o(amp_o)
    );

    // behavioural reference, written from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            m_amp = 0; m_tc = 0; m_bd = 0;
        end else if (!enable) begin
            m_tc = 0; m_bd = 0;
        end else begin
            m_wl  = (win_len == 0) ? 1 : int'(win_len);
            m_tot = m_bd + int'(breakdown);
            if (trig && (m_tc + 1 >= m_wl)) begin
                m_r = (m_tot < int'(bd_thresh)) ? m_amp + int'(step) : m_amp - int'(step);
                if (m_r > int'(amp_max)) m_r = int'(amp_max);
                if (m_r < int'(amp_min)) m_r = int'(amp_min);
                m_amp = m_r; m_tc = 0; m_bd = 0;
            end else begin
                if (trig) m_tc = m_tc + 1;
                m_bd = (m_tot > 255) ? 255 : m_tot;
            end
        end
        started = 1'b1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: amp_o actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison with the model
    always @(negedge clk) begin
        if (started && !done) check(int'(amp_o) == m_amp, cur_req, int'(amp_o), m_amp);
    end

    task automatic cyc(input bit t, input bit b);
        trig = t; breakdown = b;
        @(negedge clk);
        trig = 1'b0; breakdown = 1'b0;
    endtask

    task automatic run_window(input int nbd, input bit bd_last);
        int wl = (win_len == 0) ? 1 : int'(win_len);
        for (int i = 0; i < nbd; i++) cyc(1'b0, 1'b1);
        for (int i = 0; i < wl - 1; i++) begin
            cyc(1'b1, 1'b0);
            cyc(1'b0, 1'b0);
        end
        cyc(1'b1, bd_last);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        n_chk++; n_err++;
        $display("FAIL watchdog: run did not end, actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(amp_o == 16'd0, "R1", int'(amp_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(amp_o == 16'd0, "R1", int'(amp_o), 0);

        cur_req = "R10"; run_window(0, 1'b0);
        check(amp_o == 16'd200, "R10", int'(amp_o), 200);
        cur_req = "R3"; run_window(1, 1'b0);
        check(amp_o == 16'd300, "R3", int'(amp_o), 300);
        cur_req = "R4"; run_window(2, 1'b0);
        check(amp_o == 16'd200, "R4", int'(amp_o), 200);
        cur_req = "R7"; run_window(1, 1'b1);
        check(amp_o == 16'd200, "R7", int'(amp_o), 200);
        run_window(0, 1'b0);
        check(amp_o == 16'd300, "R7", int'(amp_o), 300);

        cur_req = "R5";
        for (int k = 0; k < 9; k++) run_window(0, 1'b0);
        check(amp_o == 16'd1000, "R5", int'(amp_o), 1000);
        step = 16'hFFF0; run_window(0, 1'b0);
        check(amp_o == 16'd1000, "R5", int'(amp_o), 1000);
        cur_req = "R6"; run_window(5, 1'b0);
        check(amp_o == 16'd200, "R6", int'(amp_o), 200);
        step = 16'd100;

        cur_req = "R8"; enable = 1'b0;
        for (int k = 0; k < 6; k++) cyc(1'b1, 1'b1);
        check(amp_o == 16'd200, "R8", int'(amp_o), 200);
        enable = 1'b1;
        cyc(1'b1, 1'b0); cyc(1'b1, 1'b0); cyc(1'b1, 1'b0);
        check(amp_o == 16'd200, "R8", int'(amp_o), 200);
        cyc(1'b1, 1'b0);
        check(amp_o == 16'd300, "R8", int'(amp_o), 300);

        cur_req = "R2"; win_len = 16'd0;
        cyc(1'b1, 1'b0);
        check(amp_o == 16'd400, "R2", int'(amp_o), 400);
        win_len = 16'd4;
        cyc(1'b1, 1'b0); cyc(1'b0, 1'b0); cyc(1'b1, 1'b0); cyc(1'b1, 1'b0);
        check(amp_o == 16'd400, "R2", int'(amp_o), 400);
        cyc(1'b1, 1'b0);
        check(amp_o == 16'd500, "R2", int'(amp_o), 500);

        cur_req = "R9"; bd_thresh = 8'd255;
        run_window(300, 1'b0);
        check(amp_o == 16'd400, "R9", int'(amp_o), 400);

        cur_req = "R10"; bd_thresh = 8'd2; amp_max = 16'd350;
        run_window(0, 1'b0);
        check(amp_o == 16'd350, "R10", int'(amp_o), 350);
        amp_max = 16'd1000;

        cur_req = "R3";
        for (int k = 0; k < 4000; k++) begin
            enable    = ($urandom_range(0, 15) != 0);
            win_len   = 16'($urandom_range(0, 5));
            bd_thresh = 8'($urandom_range(0, 3));
            step      = 16'($urandom_range(1, 400));
            cyc($urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0);
        end
        finish_run();
    end
endmodule